// File: doc/BRIEF.md
# Reference-Mode Supervisor with Holdover Memory

This block supervises a clock-synchronization loop. Two mode-control pins choose one of four operating modes: lock to reference 1, lock to reference 2, holdover, or free run. The chosen mode is shown on four one-hot indicator outputs. A single alarm output gathers every abnormal condition: the unlocked modes, a missing reference, lost lock, and a tuning word that has moved into the outer band of its range.

The loop filter supplies a signed tuning word. While the loop is locked to a present reference, the block keeps a slow, filtered history of that word, updated once per second. On the cycle that holdover is entered, the block freezes the history into a hold register. It then steers the oscillator from that frozen value until a reference mode is selected again. In free run the oscillator receives the centre (zero) word. A tri-state request input is turned into an active-high output-enable.

Top module: `refmode_supervisor`

## Requirements
- R1: The pins (ctlA, ctlB) pick the mode at each rising clock edge, so a change shows from the next cycle. 00 gives free run, 10 gives reference 1, 01 gives reference 2, and 11 gives holdover. Pins held low therefore give free run.
- R2: Exactly one of indFree, indRef1, indRef2 and indHold is high at all times. It is the one for the current mode.
- R3: While rst is high at a rising edge, the block goes to free run and the alarm reads high. The history and hold values are cleared to the centre value 0.
- R4: alarm is high when any of the following holds: the mode is free run, the mode is holdover, lossOfRef is high, lossOfLock is high, or tuneLimit is high.
- R5: tuneLimit is high, without delay, exactly when tuneIn >= 29490 or tuneIn <= -29490. This threshold is 90% of the positive full scale 32767, rounded down.
- R6: The history is updated at an edge where secStrobe is high, the mode is reference 1 or 2, and both lossOfLock and lossOfRef are low. The update is hist += (tuneIn - hist) >>> 5, using an arithmetic shift that rounds toward minus infinity.
- R7: At every other edge the history keeps its value. This includes strobes in holdover or free run, and strobes while lock or the reference is lost.
- R8: At the edge where the mode changes into holdover from any other mode, the hold register takes the history value held before that edge. It then stays unchanged for as long as holdover lasts.
- R9: tuneOut equals tuneIn in a reference mode. It equals the hold register in holdover and 0 in free run.
- R10: outEnable is the inverse of tristateReq: a low request, the default, enables the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctlA | input | 1 | Mode control pin A |
| ctlB | input | 1 | Mode control pin B |
| lossOfRef | input | 1 | Selected reference is absent |
| lossOfLock | input | 1 | Loop is not locked |
| secStrobe | input | 1 | One-per-second history update strobe |
| tuneIn | input | 16 | Signed tuning word from the loop filter |
| tristateReq | input | 1 | 1 requests the outputs disabled |
| indFree | output | 1 | Free-run mode indicator |
| indRef1 | output | 1 | Reference 1 mode indicator |
| indRef2 | output | 1 | Reference 2 mode indicator |
| indHold | output | 1 | Holdover mode indicator |
| alarm | output | 1 | Combined alarm |
| tuneLimit | output | 1 | Tuning word is in the outer 10% band |
| tuneOut | output | 16 | Signed tuning word sent to the oscillator |
| outEnable | output | 1 | Output enable, low disables |

## Verification
The bench runs a behavioural model and compares it with the design on every cycle. First, directed passes step through all four pin codes, including returning to holdover from free run. This shows whether the hold register is recaptured from a history that has not moved. Next come tuning words exactly at, and one step inside, both thresholds, plus both extreme values. These separate an off-by-one or a sign error in the limit compare. Last, strobes are applied with lock or the reference lost, followed by a long random run of mode changes, strobes and tuning words. These tell apart history updates that are gated correctly from ones that are gated wrongly, and a freeze taken in the right cycle from one taken late.

// File: rtl/refsup_pkg.sv
package refsup_pkg;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_REF1 = 2'd1,
    MODE_REF2 = 2'd2,
    MODE_HOLD = 2'd3
  } opMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic histUpdate;
    logic holdCapture;
    logic selRef;
    logic selHold;
    logic selFree;
  } ctrlStrobe_t;

  function automatic opMode_t decodePins(input logic a, input logic b);
    case ({a, b})
      2'b10:   return MODE_REF1;
      2'b01:   return MODE_REF2;
      2'b11:   return MODE_HOLD;
      default: return MODE_FREE;
    endcase
  endfunction

endpackage

// File: rtl/refsup_ctrl.sv
module refsup_ctrl
  import refsup_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctlA,
  input  logic        ctlB,
  input  logic        lossOfRef,
  input  logic        lossOfLock,
  input  logic        secStrobe,
  input  logic        tuneLimit,
  output ctrlStrobe_t stb,
  output logic        indFree,
  output logic        indRef1,
  output logic        indRef2,
  output logic        indHold,
  output logic        alarm
);

  opMode_t modeQ;
  opMode_t modeNext;
  logic    inRef;

  assign modeNext = decodePins(ctlA, ctlB);

  always_ff @(posedge clk) begin
    if (rst) modeQ <= MODE_FREE;
    else     modeQ <= modeNext;
  end

  assign inRef = (modeQ == MODE_REF1) || (modeQ == MODE_REF2);

  always_comb begin
    stb             = '0;
    stb.selRef      = inRef;
    stb.selHold     = (modeQ == MODE_HOLD);
    stb.selFree     = (modeQ == MODE_FREE);
    stb.histUpdate  = !rst && secStrobe && inRef && !lossOfLock && !lossOfRef;
    stb.holdCapture = !rst && (modeNext == MODE_HOLD) && (modeQ != MODE_HOLD);
  end

  assign indFree = (modeQ == MODE_FREE);
  assign indRef1 = (modeQ == MODE_REF1);
  assign indRef2 = (modeQ == MODE_REF2);
  assign indHold = (modeQ == MODE_HOLD);

  assign alarm = indFree || indHold || lossOfRef || lossOfLock || tuneLimit;

  AST_IND_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones({indFree, indRef1, indRef2, indHold}) == 1); // R2

  AST_PINS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctlA && ctlB) |=> indHold); // R1

  AST_PINS_FREE: assert property (@(posedge clk) disable iff (rst)
    (!ctlA && !ctlB) |=> (indFree && alarm)); // R1

  AST_LIMIT_ALARM: assert property (@(posedge clk) disable iff (rst)
    tuneLimit |-> alarm); // R4

endmodule

// File: rtl/refsup_datapath.sv
module refsup_datapath
  import refsup_pkg::*;
#(
  parameter int TW        = 16,
  parameter int SHIFT     = 5,
  parameter int LIMIT_NUM = 9,
  parameter int LIMIT_DEN = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobe_t          stb,
  input  logic signed [TW-1:0] tuneIn,
  output logic                 tuneLimit,
  output logic signed [TW-1:0] tuneOut
);

  localparam int FULL_POS = (2 ** (TW - 1)) - 1;
  localparam int LIMIT_I  = (FULL_POS * LIMIT_NUM) / LIMIT_DEN;
  localparam logic signed [TW:0] LIMIT_POS = LIMIT_I;
  localparam logic signed [TW:0] LIMIT_NEG = -LIMIT_I;

  logic signed [TW-1:0] histQ;
  logic signed [TW-1:0] holdQ;
  logic signed [TW:0]   tuneExt;
  logic signed [TW:0]   diff;
  logic signed [TW:0]   step;
  logic signed [TW:0]   histSum;

  // outer-band comparison, one extra bit so the most negative word is safe
  assign tuneExt   = {tuneIn[TW-1], tuneIn};
  assign tuneLimit = (tuneExt >= LIMIT_POS) || (tuneExt <= LIMIT_NEG);

  // first-order IIR history
  assign diff    = tuneExt - {histQ[TW-1], histQ};
  assign step    = diff >>> SHIFT;
  assign histSum = {histQ[TW-1], histQ} + step;

  always_ff @(posedge clk) begin
    if (rst)                 histQ <= '0;
    else if (stb.histUpdate) histQ <= histSum[TW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                  holdQ <= '0;
    else if (stb.holdCapture) holdQ <= histQ;
  end

  always_comb begin
    if (stb.selRef)       tuneOut = tuneIn;
    else if (stb.selHold) tuneOut = holdQ;
    else                  tuneOut = '0;
  end

  AST_HIST_QUIET: assert property (@(posedge clk) disable iff (rst)
    !stb.histUpdate |=> $stable(histQ)); // R7

  AST_UPDATE_IN_REF: assert property (@(posedge clk) disable iff (rst)
    stb.histUpdate |-> stb.selRef); // R6

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    stb.selHold |=> (!stb.selHold || $stable(holdQ))); // R8

  AST_FREE_CENTRE: assert property (@(posedge clk) disable iff (rst)
    (stb.selFree && $past(stb.selFree)) |-> (tuneOut == '0)); // R9

endmodule

// File: rtl/refmode_supervisor.sv
module refmode_supervisor
  import refsup_pkg::*;
#(
  parameter int TW    = 16,
  parameter int SHIFT = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctlA,
  input  logic                 ctlB,
  input  logic                 lossOfRef,
  input  logic                 lossOfLock,
  input  logic                 secStrobe,
  input  logic signed [TW-1:0] tuneIn,
  input  logic                 tristateReq,
  output logic                 indFree,
  output logic                 indRef1,
  output logic                 indRef2,
  output logic                 indHold,
  output logic                 alarm,
  output logic                 tuneLimit,
  output logic signed [TW-1:0] tuneOut,
  output logic                 outEnable
);

  ctrlStrobe_t stb;

  refsup_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .ctlA       (ctlA),
    .ctlB       (ctlB),
    .lossOfRef  (lossOfRef),
    .lossOfLock (lossOfLock),
    .secStrobe  (secStrobe),
    .tuneLimit  (tuneLimit),
    .stb        (stb),
    .indFree    (indFree),
    .indRef1    (indRef1),
    .indRef2    (indRef2),
    .indHold    (indHold),
    .alarm      (alarm)
  );

  refsup_datapath #(
    .TW    (TW),
    .SHIFT (SHIFT)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .tuneIn    (tuneIn),
    .tuneLimit (tuneLimit),
    .tuneOut   (tuneOut)
  );

  assign outEnable = ~tristateReq; // R10

endmodule

// File: tb/refmode_supervisor_tb.sv
module refmode_supervisor_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctlA = 1'b0, ctlB = 1'b0;
  logic lossOfRef = 1'b0, lossOfLock = 1'b0, secStrobe = 1'b0;
  logic signed [15:0] tuneIn = '0;
  logic tristateReq = 1'b0;
  logic indFree, indRef1, indRef2, indHold, alarm, tuneLimit, outEnable;
  logic signed [15:0] tuneOut;

  int checks = 0;
  int errors = 0;
  bit started = 1'b0;

  // model state: 0 free, 1 ref1, 2 ref2, 3 hold
  int mMode = 0;
  int mHist = 0;
  int mHold = 0;

  always #2.5 clk = ~clk;

  refmode_supervisor dut_i (
    .clk(clk), .rst(rst), .ctlA(ctlA), .ctlB(ctlB),
    .lossOfRef(lossOfRef), .lossOfLock(lossOfLock), .secStrobe(secStrobe),
    .tuneIn(tuneIn), .tristateReq(tristateReq),
    .indFree(indFree), .indRef1(indRef1), .indRef2(indRef2), .indHold(indHold),
    .alarm(alarm), .tuneLimit(tuneLimit), .tuneOut(tuneOut), .outEnable(outEnable)
  );

  function automatic int pinMode(input logic a, input logic b);
    if (a && !b) return 1;
    if (!a && b) return 2;
    if (a && b)  return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      mMode <= 0; mHist <= 0; mHold <= 0;
    end else begin
      int nm;
      int t;
      nm = pinMode(ctlA, ctlB);
      t  = int'(tuneIn);
      if (secStrobe && (mMode == 1 || mMode == 2) && !lossOfLock && !lossOfRef)
        mHist <= mHist + ((t - mHist) >>> 5);
      if (nm == 3 && mMode != 3) mHold <= mHist;
      mMode <= nm;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int t;
    int eLim, eAlarm, eTune;
    t = int'(tuneIn);
    eLim = (t >= 29490 || t <= -29490) ? 1 : 0;
    eAlarm = (mMode == 0 || mMode == 3 || lossOfRef || lossOfLock || eLim) ? 1 : 0;
    eTune = (mMode == 1 || mMode == 2) ? t : (mMode == 3 ? mHold : 0);
    chk("R1 R2 indicators", {indFree, indRef1, indRef2, indHold},
        {mMode == 0, mMode == 1, mMode == 2, mMode == 3});
    chk("R5 tuneLimit", int'(tuneLimit), eLim);
    chk("R4 alarm", int'(alarm), eAlarm);
    chk("R6 R7 R8 R9 tuneOut", int'(tuneOut), eTune);
    chk("R10 outEnable", int'(outEnable), int'(!tristateReq));
  endtask

  always @(negedge clk) begin
    #0.5;
    if (started) compareAll();
  end

  task automatic drive(input logic a, input logic b, input logic lor, input logic lol,
                       input logic sst, input int t, input logic ts);
    @(negedge clk);
    #1;
    ctlA = a; ctlB = b; lossOfRef = lor; lossOfLock = lol;
    secStrobe = sst; tuneIn = 16'(t); tristateReq = ts;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R3: reset state observed while reset still applied
    chk("R3 reset free indicator", int'(indFree), 1);
    chk("R3 reset alarm", int'(alarm), 1);
    chk("R3 reset tuneOut centre", int'(tuneOut), 0);
    rst = 1'b0;
    // R1 each pin code
    drive(1, 0, 0, 0, 0, 100, 0);
    drive(0, 1, 0, 0, 0, -100, 0);
    drive(1, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    // R6 build history in ref1
    for (int i = 0; i < 60; i++) drive(1, 0, 0, 0, (i % 3) == 0, 20000, 0);
    // R7 strobes without lock or reference
    for (int i = 0; i < 10; i++) drive(1, 0, i[0], !i[0], 1, -30000, 0);
    // R8 freeze, strobes during hold ignored
    for (int i = 0; i < 10; i++) drive(1, 1, 0, 0, 1, -20000, 0);
    // free then hold again: recapture same history
    drive(0, 0, 0, 0, 1, 5, 0);
    drive(1, 1, 0, 0, 1, 5, 0);
    drive(1, 1, 0, 0, 0, 5, 0);
    // R5 boundaries in ref2
    drive(0, 1, 0, 0, 0, 29490, 0);
    drive(0, 1, 0, 0, 0, 29489, 0);
    drive(0, 1, 0, 0, 0, -29490, 0);
    drive(0, 1, 0, 0, 0, -29489, 0);
    drive(0, 1, 0, 0, 0, 32767, 0);
    drive(0, 1, 0, 0, 0, -32768, 0);
    // R10 tristate
    drive(0, 1, 0, 0, 0, 0, 1);
    drive(0, 1, 0, 0, 0, 0, 0);
    // random soak
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] p;
      p = ((i % 37) == 0 || (i % 41) == 0) ? 2'($urandom) : {ctlA, ctlB};
      drive(p[1], p[0], ($urandom % 8) == 0, ($urandom % 8) == 0,
            ($urandom % 3) == 0, int'($signed(16'($urandom))), ($urandom % 16) == 0);
    end
    // reset mid-run, R3
    drive(1, 1, 0, 0, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk); #1;
    rst = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R3 history cleared by reset", int'(tuneOut), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule